// File: doc/BRIEF.md
# Sequence-Locked Watchdog Timer

This block is a watchdog timer that sits on a simple word-addressed register bus. An up-counter advances on strobes from a slow reference clock, either on every strobe or once per 2^k strobes through a prescaler. When it steps past its all-ones value it wraps, reloads from a programmable start value and raises a one-cycle reset request, which is intended to restart the system.

Software cannot start or stop the counter with a single store. It must write a matching pair of key words, in order, to a key register. Once the counter is running, software keeps the reset from firing by writing a fresh value to a kick register, which copies the start value back into the counter. The start value, kick and key registers are posted: each write is held in a staging stage for two cycles, and a pending flag shows the write is still in flight. A second interrupt source fires when the counter steps onto a programmable compare value. Both interrupt sources are maskable and their status bits are cleared by writing a one to them.

Top module: `wdt_seqlock`

## Requirements
- R1: Writing 0xBBBB and then 0x4444 to the key register (word 5, upper bits zero) makes the counter run: it advances by one per counted reference strobe.
- R2: Writing 0xAAAA and then 0x5555 to the key register stops the counter, after which reference strobes leave the counter value (word 2, read-only) unchanged.
- R3: A key write that is not the expected second word of a sequence discards the stored first word and is itself dropped, so a full sequence must follow afterwards; a lone second word does nothing.
- R4: The pending register (word 6) has bit 0 for start value (word 3), bit 1 for kick (word 4) and bit 2 for key. An accepted write sets its bit for exactly two cycles, and the write takes effect as the bit clears.
- R5: A write to a posted register while its pending bit is set is ignored.
- R6: When a counted strobe finds the counter at all ones, the counter reloads from the start value, reset request pulses high for one cycle, and status bit 0 (word 8) is set.
- R7: A kick write whose value differs from the kick register's current contents copies the start value into the counter; writing the same value leaves the counter alone.
- R8: When a counted strobe moves the counter onto the compare value (word 7), status bit 1 is set.
- R9: Interrupt enables are word 9 (bit 0 overflow, bit 1 compare); irq is high while any status bit and its enable are both set; writing one to a status bit clears it.
- R10: The prescale register (word 1) holds the exponent in bits 2:0 and the enable in bit 3; when enabled the counter advances once per 2^exponent strobes, counted from the write to this register, and when disabled once per strobe.
- R11: Writing 1 to bit 0 of the control register (word 0) resets every register of the block; the bit reads back 1 for one cycle and then 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus and counter clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ref_tick | input | 1 | One-cycle strobe per reference clock period |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | 4 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| irq | output | 1 | Interrupt request |
| rst_req | output | 1 | One-cycle reset request on overflow |

## Verification
The key logic is driven with a table of three-word key sequences: a clean start, a start preceded by noise, a repeated first word, a wrong second word, a stop half written alone, and crossed halves of the start and stop pairs. Each sequence is followed by counted strobes, and whether the counter moved shows whether the sequence opened the lock. Directed tests then cover overflow wrap and reload, the compare event, kicks with equal and changed values, the two-cycle pending window, writes made inside that window, the prescale divisor and the soft reset.

// File: rtl/wdt_seqlock.sv
module wdt_seqlock #(
  parameter int CW    = 32,
  parameter int PTV_W = 3,
  parameter int AW    = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ref_tick,
  input  logic          bus_wr,
  input  logic [AW-1:0] bus_addr,
  input  logic [31:0]   bus_wdata,
  output logic [31:0]   bus_rdata,
  output logic          irq,
  output logic          rst_req
);

  localparam int DIV_W = (1 << PTV_W) - 1;
  localparam int NSYNC = 3;

  localparam logic [AW-1:0] A_CTRL  = AW'(0);
  localparam logic [AW-1:0] A_PRESC = AW'(1);
  localparam logic [AW-1:0] A_COUNT = AW'(2);
  localparam logic [AW-1:0] A_START = AW'(3);
  localparam logic [AW-1:0] A_KICK  = AW'(4);
  localparam logic [AW-1:0] A_KEY   = AW'(5);
  localparam logic [AW-1:0] A_PEND  = AW'(6);
  localparam logic [AW-1:0] A_CMP   = AW'(7);
  localparam logic [AW-1:0] A_STAT  = AW'(8);
  localparam logic [AW-1:0] A_IEN   = AW'(9);

  localparam logic [CW-1:0] K_RUN1  = CW'(16'hBBBB);
  localparam logic [CW-1:0] K_RUN2  = CW'(16'h4444);
  localparam logic [CW-1:0] K_HALT1 = CW'(16'hAAAA);
  localparam logic [CW-1:0] K_HALT2 = CW'(16'h5555);

  typedef enum logic [1:0] {KS_IDLE, KS_RUN1, KS_HALT1} kst_t;

  logic                        clr;
  logic                        srst_q;
  logic [NSYNC-1:0]            pend;
  logic [NSYNC-1:0]            apply;
  logic [NSYNC-1:0][CW-1:0]    stage;
  logic [CW-1:0]               load_q, kick_q, cnt_q, cmp_q, cnt_nxt;
  logic [PTV_W-1:0]            ptv_q;
  logic                        pre_en_q;
  logic [DIV_W-1:0]            div_q, div_mask, one_sh;
  logic                        run_q;
  kst_t                        kst_q;
  logic [1:0]                  stat_q, ien_q;
  logic                        rst_req_q;
  logic                        cnt_tick, wrap, kick_fire, ovf_evt, cmp_evt;
  logic                        presc_wr;

  assign clr = srst_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)   srst_q <= 1'b0;
    else if (clr) srst_q <= 1'b0;
    else          srst_q <= bus_wr && bus_addr == A_CTRL && bus_wdata[0];

  localparam logic [NSYNC*AW-1:0] SYNC_ADDR = {A_KEY, A_KICK, A_START};

  for (genvar g = 0; g < NSYNC; g++) begin : g_post
    logic [1:0]    pc;
    logic [CW-1:0] st;
    logic          acc;
    assign acc = bus_wr && bus_addr == SYNC_ADDR[g*AW +: AW] && pc == 2'd0;
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
        pc <= 2'd0;
        st <= '0;
      end else if (clr) begin
        pc <= 2'd0;
        st <= '0;
      end else if (acc) begin
        pc <= 2'd2;
        st <= bus_wdata[CW-1:0];
      end else if (pc != 2'd0) begin
        pc <= pc - 2'd1;
      end
    assign pend[g]  = pc != 2'd0;
    assign apply[g] = pc == 2'd1;
    assign stage[g] = st;

    a_r5_ignore_pending: assert property (@(posedge clk) disable iff (!rst_n || clr)
      (bus_wr && bus_addr == SYNC_ADDR[g*AW +: AW] && pend[g]) |=> $stable(st));
    a_r4_pend_hold: assert property (@(posedge clk) disable iff (!rst_n || clr)
      $rose(pend[g]) |=> pend[g]);
    a_r4_pend_clear: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pend[g]) |-> ##2 !pend[g]);
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)        load_q <= '0;
    else if (clr)      load_q <= '0;
    else if (apply[0]) load_q <= stage[0];

  assign kick_fire = apply[1] && stage[1] != kick_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)        kick_q <= '0;
    else if (clr)      kick_q <= '0;
    else if (apply[1]) kick_q <= stage[1];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      kst_q <= KS_IDLE;
      run_q <= 1'b0;
    end else if (clr) begin
      kst_q <= KS_IDLE;
      run_q <= 1'b0;
    end else if (apply[2]) begin
      unique case (kst_q)
        KS_IDLE:
          if (stage[2] == K_RUN1)       kst_q <= KS_RUN1;
          else if (stage[2] == K_HALT1) kst_q <= KS_HALT1;
        KS_RUN1: begin
          kst_q <= KS_IDLE;
          if (stage[2] == K_RUN2) run_q <= 1'b1;
        end
        KS_HALT1: begin
          kst_q <= KS_IDLE;
          if (stage[2] == K_HALT2) run_q <= 1'b0;
        end
        default: kst_q <= KS_IDLE;
      endcase
    end

  assign presc_wr = bus_wr && bus_addr == A_PRESC;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      ptv_q    <= '0;
      pre_en_q <= 1'b0;
    end else if (clr) begin
      ptv_q    <= '0;
      pre_en_q <= 1'b0;
    end else if (presc_wr) begin
      ptv_q    <= bus_wdata[PTV_W-1:0];
      pre_en_q <= bus_wdata[PTV_W];
    end

  assign one_sh   = DIV_W'(1) << ptv_q;
  assign div_mask = one_sh - 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                            div_q <= '0;
    else if (clr || presc_wr || !run_q)    div_q <= '0;
    else if (ref_tick && pre_en_q)         div_q <= (div_q == div_mask) ? '0 : div_q + 1'b1;

  assign cnt_tick = run_q && ref_tick && (!pre_en_q || div_q == div_mask);
  assign wrap     = cnt_tick && cnt_q == '1;
  assign cnt_nxt  = wrap ? load_q : cnt_q + 1'b1;
  assign ovf_evt  = wrap && !kick_fire;
  assign cmp_evt  = cnt_tick && !kick_fire && cnt_nxt == cmp_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)         cnt_q <= '0;
    else if (clr)       cnt_q <= '0;
    else if (kick_fire) cnt_q <= load_q;
    else if (cnt_tick)  cnt_q <= cnt_nxt;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)   rst_req_q <= 1'b0;
    else if (clr) rst_req_q <= 1'b0;
    else          rst_req_q <= ovf_evt;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cmp_q <= '0;
      ien_q <= '0;
    end else if (clr) begin
      cmp_q <= '0;
      ien_q <= '0;
    end else if (bus_wr) begin
      if (bus_addr == A_CMP) cmp_q <= bus_wdata[CW-1:0];
      if (bus_addr == A_IEN) ien_q <= bus_wdata[1:0];
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)   stat_q <= '0;
    else if (clr) stat_q <= '0;
    else          stat_q <= (stat_q & ~((bus_wr && bus_addr == A_STAT) ? bus_wdata[1:0] : 2'b00))
                            | {cmp_evt, ovf_evt};

  assign irq     = |(stat_q & ien_q);
  assign rst_req = rst_req_q;

  always_comb
    case (bus_addr)
      A_CTRL:  bus_rdata = 32'(srst_q);
      A_PRESC: bus_rdata = 32'({pre_en_q, ptv_q});
      A_COUNT: bus_rdata = 32'(cnt_q);
      A_START: bus_rdata = 32'(load_q);
      A_KICK:  bus_rdata = 32'(kick_q);
      A_PEND:  bus_rdata = 32'(pend);
      A_CMP:   bus_rdata = 32'(cmp_q);
      A_STAT:  bus_rdata = 32'(stat_q);
      A_IEN:   bus_rdata = 32'(ien_q);
      default: bus_rdata = '0;
    endcase

  a_r6_reset_when_running: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |-> $past(run_q));
  a_r6_reload_value: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |-> cnt_q == $past(load_q));
  a_r2_stopped_holds: assert property (@(posedge clk) disable iff (!rst_n || clr)
    (!run_q && !kick_fire) |=> $stable(cnt_q));
  a_r9_w1c: assert property (@(posedge clk) disable iff (!rst_n || clr)
    (bus_wr && bus_addr == A_STAT && bus_wdata[0] && !ovf_evt) |=> !stat_q[0]);
  a_r11_self_clear: assert property (@(posedge clk) disable iff (!rst_n)
    srst_q |=> !srst_q && cnt_q == '0 && !run_q);

endmodule

// File: tb/wdt_seqlock_test.sv
module wdt_seqlock_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ref_tick = 1'b0;
  logic        bus_wr = 1'b0;
  logic [3:0]  bus_addr = 4'd0;
  logic [31:0] bus_wdata = 32'd0;
  logic [31:0] bus_rdata;
  logic        irq, rst_req;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  wdt_seqlock uut (
    .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq(irq), .rst_req(rst_req)
  );

  // key words w1, w2, w3, then 1 when the counter must be running afterwards
  localparam logic [48:0] VEC [0:7] = '{
    {16'hBBBB, 16'h4444, 16'h0000, 1'b1},
    {16'hBBBB, 16'hBBBB, 16'h4444, 1'b0},
    {16'hBBBB, 16'h1234, 16'h4444, 1'b0},
    {16'h4444, 16'hBBBB, 16'h4444, 1'b1},
    {16'hAAAA, 16'h4444, 16'h0000, 1'b0},
    {16'hBBBB, 16'h5555, 16'h0000, 1'b0},
    {16'h1111, 16'hBBBB, 16'h4444, 1'b1},
    {16'hBBBB, 16'h4444, 16'hAAAA, 1'b1}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic wr_sync(input logic [3:0] a, input logic [31:0] d);
    wr(a, d);
    repeat (2) @(negedge clk);
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); ref_tick = 1'b1;
      @(negedge clk); ref_tick = 1'b0;
    end
  endtask

  task automatic soft_reset;
    wr(4'd0, 32'd1);
    @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // reset state
    rd(4'd2, d); chk("R11 reset count", d, 32'd0);
    rd(4'd6, d); chk("R4 reset pending", d, 32'd0);
    rd(4'd8, d); chk("R9 reset status", d, 32'd0);
    chk("R9 reset irq", 32'(irq), 32'd0);
    chk("R6 reset rst_req", 32'(rst_req), 32'd0);

    // key sequence table
    for (int v = 0; v < 8; v++) begin
      soft_reset();
      wr_sync(4'd3, 32'd100);
      wr_sync(4'd4, 32'd1);
      rd(4'd2, d); chk("R7 kick load", d, 32'd100);
      wr_sync(4'd5, 32'(VEC[v][48:33]));
      wr_sync(4'd5, 32'(VEC[v][32:17]));
      wr_sync(4'd5, 32'(VEC[v][16:1]));
      ticks(3);
      rd(4'd2, d);
      chk(VEC[v][0] ? "R1 key start" : "R3 key discard", d, VEC[v][0] ? 32'd103 : 32'd100);
    end

    // overflow
    soft_reset();
    wr_sync(4'd3, 32'hFFFF_FFFD);
    wr_sync(4'd4, 32'd5);
    wr(4'd9, 32'd1);
    wr_sync(4'd5, 32'hBBBB);
    wr_sync(4'd5, 32'h4444);
    ticks(2);
    rd(4'd2, d); chk("R1 count up", d, 32'hFFFF_FFFF);
    chk("R6 no early reset", 32'(rst_req), 32'd0);
    @(negedge clk); ref_tick = 1'b1;
    @(negedge clk); ref_tick = 1'b0;
    #1;
    chk("R6 rst_req pulse", 32'(rst_req), 32'd1);
    rd(4'd2, d); chk("R6 reload", d, 32'hFFFF_FFFD);
    rd(4'd8, d); chk("R6 overflow status", d, 32'd1);
    chk("R9 irq overflow", 32'(irq), 32'd1);
    @(negedge clk); #1;
    chk("R6 one-cycle pulse", 32'(rst_req), 32'd0);
    wr(4'd8, 32'd1);
    #1;
    chk("R9 w1c irq", 32'(irq), 32'd0);
    rd(4'd8, d); chk("R9 w1c status", d, 32'd0);

    // compare event
    wr(4'd7, 32'hFFFF_FFFE);
    wr(4'd9, 32'd2);
    ticks(1);
    rd(4'd8, d); chk("R8 compare status", d, 32'd2);
    chk("R9 irq compare", 32'(irq), 32'd1);

    // kick with equal and changed values
    wr_sync(4'd4, 32'd5);
    rd(4'd2, d); chk("R7 same kick no effect", d, 32'hFFFF_FFFE);
    wr_sync(4'd4, 32'd6);
    rd(4'd2, d); chk("R7 changed kick reload", d, 32'hFFFF_FFFD);

    // write while pending is ignored
    @(negedge clk); bus_wr = 1'b1; bus_addr = 4'd3; bus_wdata = 32'h10;
    @(negedge clk); bus_wdata = 32'h20;
    @(negedge clk); bus_wr = 1'b0;
    rd(4'd6, d); chk("R4 pending start value", d, 32'd1);
    @(negedge clk);
    rd(4'd6, d); chk("R4 pending cleared", d, 32'd0);
    rd(4'd3, d); chk("R5 ignored write", d, 32'h10);

    // two-cycle pending window on kick
    @(negedge clk); bus_wr = 1'b1; bus_addr = 4'd4; bus_wdata = 32'd7;
    @(negedge clk); bus_wr = 1'b0;
    rd(4'd6, d); chk("R4 kick pending 1", d, 32'd2);
    rd(4'd2, d); chk("R4 not yet applied", d, 32'hFFFF_FFFD);
    @(negedge clk);
    rd(4'd6, d); chk("R4 kick pending 2", d, 32'd2);
    @(negedge clk);
    rd(4'd6, d); chk("R4 kick done", d, 32'd0);
    rd(4'd2, d); chk("R4 applied", d, 32'h10);

    // prescaler
    wr(4'd1, 32'hA);
    ticks(3);
    rd(4'd2, d); chk("R10 divided hold", d, 32'h10);
    ticks(1);
    rd(4'd2, d); chk("R10 divided step", d, 32'h11);
    wr(4'd1, 32'h2);
    ticks(1);
    rd(4'd2, d); chk("R10 disabled", d, 32'h12);

    // stop
    wr_sync(4'd5, 32'hAAAA);
    wr_sync(4'd5, 32'h5555);
    ticks(2);
    rd(4'd2, d); chk("R2 stopped", d, 32'h12);

    // soft reset
    @(negedge clk); bus_wr = 1'b1; bus_addr = 4'd0; bus_wdata = 32'd1;
    @(negedge clk); bus_wr = 1'b0;
    rd(4'd0, d); chk("R11 bit set", d, 32'd1);
    @(negedge clk);
    rd(4'd0, d); chk("R11 bit cleared", d, 32'd0);
    rd(4'd3, d); chk("R11 start value", d, 32'd0);
    rd(4'd2, d); chk("R11 count", d, 32'd0);
    rd(4'd9, d); chk("R11 enables", d, 32'd0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule